// File: doc/BRIEF.md
# Linear Frequency Sweep Controller

This block produces the frequency word (the per-clock phase increment) for a phase-accumulator oscillator so that the synthesized frequency ramps linearly from a programmed start value up to a programmed stop value. The word is held in a register and advances by a programmable step on each sweep tick. A programmable divider derives the sweep tick from the system clock, so the sweep rate is independent of the oscillator clock.

The sweep is armed by a start pulse and paced by a run enable. In single-shot mode the word parks at the stop value and a one-clock completion pulse is raised. In repeat mode the word returns to the start value and the ramp begins again. The word is only ever stepped and never cleared, so the downstream accumulator keeps its phase and the waveform stays continuous through every frequency change. The word saturates at the lower of two values: one third of the accumulator modulus, which is the practical output ceiling, and the largest value the word width can hold.

Top module: `freq_sweep_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, freq_word becomes 0 and done becomes 0, and no sweep is active afterwards until start is pulsed.
- R2: A clock edge with start high loads freq_word with the (clamped) start value, makes the sweep active and restarts the rate divider, whatever the state of run_en.
- R3: With rate_div = D and run_en high, an active sweep updates freq_word exactly once every D+1 clocks, the first update coming D+1 clocks after the start edge.
- R4: On an update that does not reach the stop value, freq_word increases by step_word.
- R5: In single-shot mode (loop_mode = 0), an update whose result is greater than or equal to the stop value sets freq_word to the stop value, ends the sweep, and the word then holds. A stop value below the start value ends the sweep on the first update.
- R6: done is high for exactly one clock, in the clock that follows the edge on which a single-shot sweep ends, and is low at all other times.
- R7: In repeat mode (loop_mode = 1), an update whose result is greater than or equal to the stop value reloads the start value, the sweep continues, and done stays low.
- R8: While run_en is low, freq_word holds and the divider count is frozen; after run_en returns high the next update comes D+1 clocks later when it was frozen just after an update.
- R9: freq_word never exceeds LIMIT = min(floor(2^ACC_W / 3), 2^WORD_W - 1); an increment that would pass LIMIT saturates there and never wraps around.
- R10: freq_word changes only on a clock edge with start high or with a sweep tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Lets the divider run and the sweep advance; low freezes the sweep |
| start | input | 1 | Loads the start value and arms a new sweep |
| loop_mode | input | 1 | 0 = single-shot, 1 = repeat |
| rate_div | input | DIV_W | Tick period minus one, in clocks |
| start_word | input | WORD_W | Sweep start frequency word |
| stop_word | input | WORD_W | Sweep stop frequency word |
| step_word | input | WORD_W | Increment applied on each tick |
| freq_word | output | WORD_W | Frequency word to the phase accumulator |
| done | output | 1 | One-clock pulse when a single-shot sweep ends |

## Verification
The embedded properties watch, on every cycle, that the word stays at or below the saturation limit, that it moves only on a start or a tick, that a start lands the clamped start value, that done never lasts two clocks and coincides with the sweep going idle, and that no tick escapes while the divider is disabled. What only the directed scenarios can show are the actual sweep values and their timing: the D+1 clock spacing, the exact overshoot handling against the stop value in both modes, the resume timing after a freeze, and that a saturating step does not wrap to a small word.

// File: rtl/sweep_pkg.sv
// Package: shared definitions for the frequency sweep controller.
// Assumes word and accumulator widths of at most 63 bits.
package sweep_pkg;

    typedef enum logic {
        MODE_ONCE = 1'b0,
        MODE_LOOP = 1'b1
    } sweep_mode_e;

    // Saturation ceiling: lower of one third of the accumulator modulus
    // and the largest value representable in the word.
    function automatic logic [63:0] word_limit(input int unsigned acc_w,
                                               input int unsigned word_w);
        logic [63:0] third;
        logic [63:0] wmax;
        third = (64'd1 << acc_w) / 64'd3;
        wmax  = (64'd1 << word_w) - 64'd1;
        return (third < wmax) ? third : wmax;
    endfunction

endpackage

// File: rtl/sweep_tick_gen.sv
// Module: sweep_tick_gen
// Divides the system clock into a one-clock sweep tick every
// div_ratio+1 clocks while enabled. The count freezes when disabled and
// returns to zero on clear. Assumes div_ratio may change at any time;
// a ratio lowered below the current count fires on the next cycle.
module sweep_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_ratio,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             at_end;

    // Terminal count detection
    assign at_end = (cnt_q >= div_ratio);
    assign tick   = enable && !clear && at_end;

    // Divider counter: clears, freezes or counts up and wraps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (enable) begin
            if (at_end) cnt_q <= '0;
            else        cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8
    tick_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !tick);

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_ratio != '0 && $stable(div_ratio)) |=> !tick);

endmodule

// File: rtl/sweep_word_core.sv
// Module: sweep_word_core
// Holds the frequency word and the sweep state. A load copies the clamped
// start value; each tick adds the step with saturation at LIMIT and
// compares against the clamped stop value to end or restart the sweep.
// Assumes an upward sweep; a stop value at or below the start ends the
// sweep on the first tick.
module sweep_word_core #(
    parameter int                 WORD_W = 28,
    parameter logic [WORD_W-1:0]  LIMIT  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              tick,
    input  logic              loop_mode,
    input  logic [WORD_W-1:0] start_word,
    input  logic [WORD_W-1:0] stop_word,
    input  logic [WORD_W-1:0] step_word,
    output logic [WORD_W-1:0] freq_word,
    output logic              active,
    output logic              done
);
    import sweep_pkg::*;

    logic [WORD_W-1:0] start_c;
    logic [WORD_W-1:0] stop_c;
    logic [WORD_W:0]   sum_w;
    logic [WORD_W-1:0] next_w;
    logic              reached;
    sweep_mode_e       mode;

    // Clamp programmed bounds, form the saturated next word, detect the end
    always_comb begin
        start_c = (start_word > LIMIT) ? LIMIT : start_word;
        stop_c  = (stop_word  > LIMIT) ? LIMIT : stop_word;
        sum_w   = {1'b0, freq_word} + {1'b0, step_word};
        next_w  = (sum_w > {1'b0, LIMIT}) ? LIMIT : sum_w[WORD_W-1:0];
        reached = (next_w >= stop_c);
        mode    = sweep_mode_e'(loop_mode);
    end

    // Word register, sweep-active flag and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_word <= '0;
            active    <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                freq_word <= start_c;
                active    <= 1'b1;
            end else if (tick && active) begin
                if (!reached) begin
                    freq_word <= next_w;
                end else if (mode == MODE_LOOP) begin
                    freq_word <= start_c;
                end else begin
                    freq_word <= stop_c;
                    active    <= 1'b0;
                    done      <= 1'b1;
                end
            end
        end
    end

    // R9
    word_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freq_word <= LIMIT);

    // R10
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(freq_word));

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (freq_word == $past(start_c)) && active);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !active);

endmodule

// File: rtl/freq_sweep_ctrl.sv
// Module: freq_sweep_ctrl (top)
// Linear frequency sweep controller. Drives the increment input of an
// external phase accumulator of ACC_W bits with a WORD_W-bit word that
// ramps from start_word to stop_word in steps of step_word, one step per
// rate_div+1 clocks. Never resets the accumulator, so phase stays
// continuous. Assumes synchronous active-low reset.
module freq_sweep_ctrl #(
    parameter int WORD_W = 28,
    parameter int ACC_W  = 32,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              start,
    input  logic              loop_mode,
    input  logic [DIV_W-1:0]  rate_div,
    input  logic [WORD_W-1:0] start_word,
    input  logic [WORD_W-1:0] stop_word,
    input  logic [WORD_W-1:0] step_word,
    output logic [WORD_W-1:0] freq_word,
    output logic              done
);

    localparam logic [63:0]       LIM64 = sweep_pkg::word_limit(ACC_W, WORD_W);
    localparam logic [WORD_W-1:0] LIMIT = LIM64[WORD_W-1:0];

    logic sweep_active;
    logic div_enable;
    logic sweep_tick;

    // Divider runs only while a sweep is armed and running
    assign div_enable = run_en && sweep_active;

    sweep_tick_gen #(
        .DIV_W (DIV_W)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .enable    (div_enable),
        .div_ratio (rate_div),
        .tick      (sweep_tick)
    );

    sweep_word_core #(
        .WORD_W (WORD_W),
        .LIMIT  (LIMIT)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start),
        .tick       (sweep_tick),
        .loop_mode  (loop_mode),
        .start_word (start_word),
        .stop_word  (stop_word),
        .step_word  (step_word),
        .freq_word  (freq_word),
        .active     (sweep_active),
        .done       (done)
    );

endmodule

// File: tb/tb_freq_sweep_ctrl.sv
`timescale 1ns/1ps
module tb_freq_sweep_ctrl;

    localparam int WORD_W = 28;
    localparam int DIV_W  = 16;
    localparam logic [WORD_W-1:0] WMAX = 28'hFFFFFFF;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              run_en;
    logic              start;
    logic              loop_mode;
    logic [DIV_W-1:0]  rate_div;
    logic [WORD_W-1:0] start_word;
    logic [WORD_W-1:0] stop_word;
    logic [WORD_W-1:0] step_word;
    logic [WORD_W-1:0] freq_word;
    logic              done;

    int n_checks = 0;
    int n_fails  = 0;
    logic seen_done;

    always #5 clk = ~clk;

    freq_sweep_ctrl dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .start(start),
        .loop_mode(loop_mode), .rate_div(rate_div), .start_word(start_word),
        .stop_word(stop_word), .step_word(step_word),
        .freq_word(freq_word), .done(done)
    );

    task automatic chk_word(input string req, input logic [WORD_W-1:0] exp_v);
        n_checks++;
        if (freq_word !== exp_v) begin
            n_fails++;
            $display("FAIL %s: freq_word actual %0d expected %0d", req, freq_word, exp_v);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fails++;
            $display("FAIL %s: flag actual %0b expected %0b", req, act, exp_v);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Waits n clocks while recording any done pulse
    task automatic wait_watch(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (done === 1'b1) seen_done = 1'b1;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic test_reset();
        rst_n = 1'b0; run_en = 1'b0; start = 1'b0; loop_mode = 1'b0;
        rate_div = '0; start_word = '0; stop_word = '0; step_word = '0;
        wait_n(4);
        chk_word("R1 reset word", 28'd0);
        chk_bit("R1 reset done", done, 1'b0);
        rst_n = 1'b1;
        run_en = 1'b1;
        step_word = 28'd9; stop_word = 28'd1000;
        wait_n(10);
        chk_word("R1 idle until start", 28'd0);
    endtask

    task automatic test_single();
        rate_div = 16'd3; start_word = 28'd100; stop_word = 28'd125;
        step_word = 28'd10; loop_mode = 1'b0; run_en = 1'b1;
        pulse_start();
        chk_word("R2 start load", 28'd100);
        wait_n(3);
        chk_word("R3 no early update", 28'd100);
        wait_n(1);
        chk_word("R4 first step", 28'd110);
        chk_bit("R6 no done mid sweep", done, 1'b0);
        wait_n(4);
        chk_word("R4 second step", 28'd120);
        wait_n(3);
        chk_bit("R6 done not early", done, 1'b0);
        wait_n(1);
        chk_word("R5 passed stop clamps to stop", 28'd125);
        chk_bit("R6 done pulse", done, 1'b1);
        wait_n(1);
        chk_bit("R6 done one clock", done, 1'b0);
        wait_n(20);
        chk_word("R5 holds after end", 28'd125);
        chk_bit("R6 done stays low", done, 1'b0);
    endtask

    task automatic test_loop();
        rate_div = 16'd1; start_word = 28'd50; stop_word = 28'd80;
        step_word = 28'd10; loop_mode = 1'b1;
        pulse_start();
        seen_done = 1'b0;
        wait_watch(2);
        chk_word("R4 loop step 1", 28'd60);
        wait_watch(2);
        chk_word("R4 loop step 2", 28'd70);
        wait_watch(2);
        chk_word("R7 reload at stop", 28'd50);
        wait_watch(2);
        chk_word("R7 continues", 28'd60);
        wait_watch(12);
        chk_bit("R7 no done in repeat", seen_done, 1'b0);
    endtask

    task automatic test_freeze();
        rate_div = 16'd2; start_word = 28'd1000; stop_word = 28'd2000000;
        step_word = 28'd7; loop_mode = 1'b0;
        pulse_start();
        wait_n(3);
        chk_word("R3 period three", 28'd1007);
        run_en = 1'b0;
        wait_n(25);
        chk_word("R8 frozen word", 28'd1007);
        run_en = 1'b1;
        wait_n(2);
        chk_word("R8 divider frozen count", 28'd1007);
        wait_n(1);
        chk_word("R8 resume update", 28'd1014);
    endtask

    task automatic test_restart();
        run_en = 1'b0;
        start_word = 28'd5000;
        pulse_start();
        chk_word("R2 start while stopped", 28'd5000);
        wait_n(10);
        chk_word("R8 stopped after start", 28'd5000);
        run_en = 1'b1;
        wait_n(3);
        chk_word("R3 first update after resume", 28'd5007);
        start_word = 28'd300;
        pulse_start();
        chk_word("R2 restart mid sweep", 28'd300);
    endtask

    task automatic test_saturate();
        rate_div = 16'd0; start_word = WMAX - 28'd50; stop_word = WMAX;
        step_word = 28'hFFFFFF0; loop_mode = 1'b0;
        pulse_start();
        chk_word("R2 near-limit start", WMAX - 28'd50);
        wait_n(1);
        chk_word("R9 saturates not wraps", WMAX);
        chk_bit("R6 done at saturated stop", done, 1'b1);
        loop_mode = 1'b1;
        pulse_start();
        wait_n(1);
        chk_word("R9 repeat after saturation", WMAX - 28'd50);
    endtask

    task automatic test_reverse();
        rate_div = 16'd0; start_word = 28'd900; stop_word = 28'd400;
        step_word = 28'd5; loop_mode = 1'b0;
        pulse_start();
        chk_word("R2 reverse start", 28'd900);
        wait_n(1);
        chk_word("R5 stop below start", 28'd400);
        chk_bit("R6 done reverse", done, 1'b1);
        wait_n(5);
        chk_word("R10 no change when idle", 28'd400);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        test_reset();
        test_single();
        test_loop();
        test_freeze();
        test_restart();
        test_saturate();
        test_reverse();
        finish_run();
    end

    initial begin
        #1000000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not end, actual hung expected finished");
        finish_run();
    end

endmodule